// File: doc/BRIEF.md
# Event-Mapped Trigger Generator

This block sits on the receive side of an event-based timing network. Each clock cycle it may be handed one decoded event code, marked by a valid strobe. A lookup table indexed by that code gives a mask of the trigger channels the code fires. A fired channel waits a programmed number of event-clock cycles and then drives a pulse of a programmed length. A per-channel polarity bit sets the output sense, so an inverted channel idles high.

Two routing stages follow the channels. The rear outputs carry trigger channel n on output n. Each front output has its own selector, which picks either any trigger channel or any bit of the 8-bit distributed bus. The bus bits come from clock dividers upstream and pass straight through. All settings are loaded through a simple write port: one address, one data word and one enable, with effect from the following cycle.

Top module: `evt_trig_gen`

## Requirements
- R1: After reset every mapping entry is empty, every delay, width and polarity is zero and every front selector picks trigger channel 0. In that state all rear and front outputs are low.
- R2: An event code sampled with `evt_valid_i` high fires every channel whose bit is set in that code's 12-bit mapping entry (bit n is channel n). A code whose entry is zero, or a code presented with `evt_valid_i` low, fires nothing.
- R3: A channel fired at clock edge k with delay D drives its active level from edge k+D. With D = 0 the output is active right after edge k.
- R4: A channel with width W stays active for exactly W cycles, from edge k+D to edge k+D+W, and then returns to idle.
- R5: A channel whose width is 0 is disabled. Its output stays at the idle level whatever events arrive.
- R6: A fire that reaches a channel already waiting or pulsing restarts its sequence. The delay is counted again from the new event, and no pulse appears for the earlier event.
- R7: Polarity bit 0 of a channel set to 1 inverts that channel after pulse generation: it idles high and goes low for the pulse.
- R8: Rear output n always carries trigger channel n, polarity included.
- R9: Front selector data bit 4 picks the source. When it is 1, the front output follows distributed-bus bit data[2:0] in the same cycle. When it is 0, it follows trigger channel data[3:0], polarity included. A trigger index of 12 or more gives a constant low.
- R10: Register addresses: 0x000 to 0x0FF hold the mapping entry for the code equal to the low 8 address bits. 0x100 + 4*n holds the delay of channel n, 0x101 + 4*n its width and 0x102 + 4*n its polarity. 0x140 + f holds the selector of front output f. A write takes effect at the clock edge that samples it.
- R11: When a mapping write and an event with the same code are sampled on the same edge, the event uses the entry held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_code_i | input | 8 | Decoded event code |
| evt_valid_i | input | 1 | Event code is present this cycle |
| dbus_i | input | 8 | Distributed-bus bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 10 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rear_o | output | 12 | Rear outputs, one per trigger channel |
| front_o | output | 8 | Front outputs, routed trigger or bus bit |

## Verification
Two functions can land on the same edge. A write to a mapping entry can coincide with an event that looks up that entry, and a second fire can reach a channel that is still counting down from an earlier one. The bench sets off the first by driving the write port and the event inputs on the same cycle for a code whose entry is still empty. It then expects no pulse, and it expects a pulse only from a later event with the same code. It sets off the second by sending a code twice, two cycles apart, to a channel with a delay of four. It judges the result at the port: no pulse where the first event would have placed one, and a single pulse four cycles after the second event.

// File: rtl/evt_trig_pkg.sv
// Package evt_trig_pkg
// Holds the register address layout and the small enumerations shared by
// the trigger generator modules. Assumes a 10-bit write address.
package evt_trig_pkg;

    localparam int ADDR_W        = 10;
    localparam int FRONT_SRC_BIT = 4;

    // Upper address bits that select the channel page (0x100..0x13F).
    localparam logic [3:0] PAGE_CHAN  = 4'b0100;
    // Upper address bits that select the front page (0x140..0x147).
    localparam logic [6:0] PAGE_FRONT = 7'b0101000;

    typedef enum logic [1:0] {
        FLD_DELAY = 2'd0,
        FLD_WIDTH = 2'd1,
        FLD_POL   = 2'd2,
        FLD_RSVD  = 2'd3
    } chan_fld_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_WAIT  = 2'd1,
        CH_PULSE = 2'd2
    } chan_state_e;

endpackage

// File: rtl/evt_trig_regs.sv
// Module evt_trig_regs
// Configuration store: the code-indexed mapping table, per-channel delay,
// width and polarity, and the front selectors. It also performs the mapping
// lookup. The fire mask is combinational from the registered table, so a
// write and a lookup on the same edge see the old entry.
// Assumes NUM_CH <= 16, NUM_FRONT <= 8 and CODE_W <= 8, to fit the address layout.
module evt_trig_regs
    import evt_trig_pkg::*;
#(
    parameter int NUM_CH    = 12,
    parameter int NUM_FRONT = 8,
    parameter int CODE_W    = 8,
    parameter int CNT_W     = 32,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [CODE_W-1:0]                 evt_code,
    input  logic                              evt_valid,
    output logic [NUM_CH-1:0]                 fire_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]      delay_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]      width_o,
    output logic [NUM_CH-1:0]                 pol_o,
    output logic [NUM_FRONT-1:0]              fsrc_o,
    output logic [NUM_FRONT-1:0][IDX_W-1:0]   fidx_o
);

    localparam int NUM_CODES = 1 << CODE_W;

    logic [NUM_CODES-1:0][NUM_CH-1:0] map_q;
    logic                             is_map;
    logic                             is_chan;
    logic                             is_front;
    logic [3:0]                       ch_sel;
    chan_fld_e                        fld;
    logic [2:0]                       f_sel;

    // Split the write address into page, index and field.
    always_comb begin
        is_map   = wr_en && (wr_addr[ADDR_W-1 -: 2] == 2'b00);
        is_chan  = wr_en && (wr_addr[ADDR_W-1 -: 4] == PAGE_CHAN);
        is_front = wr_en && (wr_addr[ADDR_W-1 -: 7] == PAGE_FRONT);
        ch_sel   = wr_addr[5:2];
        fld      = chan_fld_e'(wr_addr[1:0]);
        f_sel    = wr_addr[2:0];
    end

    // Mapping table: one channel mask per event code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CODES; c++) begin
                map_q[c] <= '0;
            end
        end else if (is_map) begin
            map_q[wr_addr[CODE_W-1:0]] <= wr_data[NUM_CH-1:0];
        end
    end

    // Per-channel delay, width and polarity registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_o <= '0;
            width_o <= '0;
            pol_o   <= '0;
        end else if (is_chan) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_sel == 4'(i)) begin
                    case (fld)
                        FLD_DELAY: delay_o[i] <= wr_data[CNT_W-1:0];
                        FLD_WIDTH: width_o[i] <= wr_data[CNT_W-1:0];
                        FLD_POL:   pol_o[i]   <= wr_data[0];
                        default:   ;
                    endcase
                end
            end
        end
    end

    // Front selectors: source bit and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsrc_o <= '0;
            fidx_o <= '0;
        end else if (is_front) begin
            for (int f = 0; f < NUM_FRONT; f++) begin
                if (f_sel == 3'(f)) begin
                    fsrc_o[f] <= wr_data[FRONT_SRC_BIT];
                    fidx_o[f] <= wr_data[IDX_W-1:0];
                end
            end
        end
    end

    // Lookup of the channels fired by the current event.
    always_comb begin
        fire_o = evt_valid ? map_q[evt_code] : '0;
    end

    AST_MAP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        is_map |=> (map_q[$past(wr_addr[CODE_W-1:0])] == $past(wr_data[NUM_CH-1:0]))); // R10

    AST_NO_FIRE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |-> (fire_o == '0)); // R2

endmodule

// File: rtl/evt_trig_chan.sv
// Module evt_trig_chan
// One trigger channel. A fire starts (or restarts) a delay countdown and
// then a pulse of the programmed width. A width of 0 holds the channel idle.
// Polarity is applied to the registered pulse, so an inverted channel idles high.
// Assumes the delay and width inputs are static registers.
module evt_trig_chan
    import evt_trig_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [CNT_W-1:0] delay_i,
    input  logic [CNT_W-1:0] width_i,
    input  logic             pol_i,
    output logic             trig_o
);

    chan_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;

    // Delay and pulse sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (width_i == '0) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (fire_i) begin
            if (delay_i == '0) begin
                state_q <= CH_PULSE;
                cnt_q   <= width_i - 1'b1;
                pulse_q <= 1'b1;
            end else begin
                state_q <= CH_WAIT;
                cnt_q   <= delay_i - 1'b1;
                pulse_q <= 1'b0;
            end
        end else begin
            case (state_q)
                CH_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= CH_PULSE;
                        cnt_q   <= width_i - 1'b1;
                        pulse_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                CH_PULSE: begin
                    if (cnt_q == '0) begin
                        state_q <= CH_IDLE;
                        pulse_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= CH_IDLE;
                    pulse_q <= 1'b0;
                end
            endcase
        end
    end

    // Output sense.
    always_comb begin
        trig_o = pulse_q ^ pol_i;
    end

    AST_WIDTH_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (width_i == '0) |=> !pulse_q); // R5

    AST_FIRE_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && width_i != '0 && delay_i == '0) |=> pulse_q); // R3

    AST_FIRE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && width_i != '0 && delay_i != '0) |=> (!pulse_q && state_q == CH_WAIT)); // R6

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE) |-> !pulse_q); // R4

    AST_QUIET_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_i && state_q == CH_IDLE) |=> !pulse_q); // R2

endmodule

// File: rtl/evt_trig_xbar.sv
// Module evt_trig_xbar
// Output routing. Rear outputs take the trigger channels one-to-one. Each
// front output picks a trigger channel or a distributed-bus bit. An
// out-of-range trigger index yields low. Purely combinational.
module evt_trig_xbar #(
    parameter int NUM_CH    = 12,
    parameter int NUM_FRONT = 8,
    parameter int DBUS_W    = 8,
    parameter int IDX_W     = 4
) (
    input  logic [NUM_CH-1:0]               trig_i,
    input  logic [DBUS_W-1:0]               dbus_i,
    input  logic [NUM_FRONT-1:0]            fsrc_i,
    input  logic [NUM_FRONT-1:0][IDX_W-1:0] fidx_i,
    output logic [NUM_CH-1:0]               rear_o,
    output logic [NUM_FRONT-1:0]            front_o
);

    localparam int DB_IDX_W = $clog2(DBUS_W);

    // Rear routing: channel n to output n.
    always_comb begin
        rear_o = trig_i;
    end

    for (genvar f = 0; f < NUM_FRONT; f++) begin : g_front
        // Front routing for output f.
        always_comb begin
            if (fsrc_i[f]) begin
                front_o[f] = dbus_i[fidx_i[f][DB_IDX_W-1:0]];
            end else if (fidx_i[f] < IDX_W'(NUM_CH)) begin
                front_o[f] = trig_i[fidx_i[f]];
            end else begin
                front_o[f] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/evt_trig_gen.sv
// Module evt_trig_gen
// Top level of the event-mapped trigger generator: the configuration store
// with the mapping lookup, one sequencer per trigger channel, and the output
// routing. Assumes the event code and the bus are synchronous to clk.
module evt_trig_gen
    import evt_trig_pkg::*;
#(
    parameter int NUM_CH    = 12,
    parameter int NUM_FRONT = 8,
    parameter int DBUS_W    = 8,
    parameter int CODE_W    = 8,
    parameter int CNT_W     = 32,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CODE_W-1:0]    evt_code_i,
    input  logic                 evt_valid_i,
    input  logic [DBUS_W-1:0]    dbus_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic [NUM_CH-1:0]    rear_o,
    output logic [NUM_FRONT-1:0] front_o
);

    localparam int IDX_W = 4;

    logic [NUM_CH-1:0]               fire;
    logic [NUM_CH-1:0][CNT_W-1:0]    delay;
    logic [NUM_CH-1:0][CNT_W-1:0]    width;
    logic [NUM_CH-1:0]               pol;
    logic [NUM_FRONT-1:0]            fsrc;
    logic [NUM_FRONT-1:0][IDX_W-1:0] fidx;
    logic [NUM_CH-1:0]               trig;

    evt_trig_regs #(
        .NUM_CH(NUM_CH), .NUM_FRONT(NUM_FRONT), .CODE_W(CODE_W),
        .CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .evt_code(evt_code_i), .evt_valid(evt_valid_i),
        .fire_o(fire), .delay_o(delay), .width_o(width), .pol_o(pol),
        .fsrc_o(fsrc), .fidx_o(fidx)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        evt_trig_chan #(.CNT_W(CNT_W)) chan_i (
            .clk(clk), .rst_n(rst_n),
            .fire_i(fire[i]), .delay_i(delay[i]), .width_i(width[i]),
            .pol_i(pol[i]), .trig_o(trig[i])
        );
    end

    evt_trig_xbar #(
        .NUM_CH(NUM_CH), .NUM_FRONT(NUM_FRONT), .DBUS_W(DBUS_W), .IDX_W(IDX_W)
    ) xbar_i (
        .trig_i(trig), .dbus_i(dbus_i), .fsrc_i(fsrc), .fidx_i(fidx),
        .rear_o(rear_o), .front_o(front_o)
    );

endmodule

// File: tb/evt_trig_gen_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: scenario code pushes expected output vectors tagged with
// a cycle number; a monitor pops and compares them in that cycle.
module evt_trig_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  evt_code;
    logic        evt_valid;
    logic [7:0]  dbus;
    logic        wr_en;
    logic [9:0]  wr_addr;
    logic [31:0] wr_data;
    logic [11:0] rear_o;
    logic [7:0]  front_o;

    always #2.5 clk = ~clk;

    evt_trig_gen dut_i (
        .clk(clk), .rst_n(rst_n), .evt_code_i(evt_code), .evt_valid_i(evt_valid),
        .dbus_i(dbus), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rear_o(rear_o), .front_o(front_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          cyc;
        logic [11:0] rear;
        logic [7:0]  front;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    bit    fsrc[8];
    int    fidx[8];

    // Front outputs expected from the selector settings (R9).
    function automatic logic [7:0] exp_front(logic [11:0] r);
        logic [7:0] v;
        for (int f = 0; f < 8; f++) begin
            if (fsrc[f])        v[f] = dbus[fidx[f] % 8];
            else if (fidx[f] < 12) v[f] = r[fidx[f]];
            else                v[f] = 1'b0;
        end
        return v;
    endfunction

    task automatic expect_rear(int c, logic [11:0] r, string tag);
        item_t it;
        it.cyc = c; it.rear = r; it.front = exp_front(r); it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 10'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_chan(int ch, int dly, int wid);
        wr(256 + ch * 4, dly);
        wr(257 + ch * 4, wid);
    endtask

    task automatic set_front(int f, bit src, int idx);
        wr(320 + f, (int'(src) << 4) | idx);
        fsrc[f] = src; fidx[f] = idx;
    endtask

    task automatic send_evt(int code);
        evt_code = 8'(code); evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: compare queued expectations in their cycle.
    always @(negedge clk) begin
        item_t it;
        #1;
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
            it = sb_q.pop_front();
            checks += 1;
            if (it.cyc != cyc || rear_o !== it.rear || front_o !== it.front) begin
                errors += 1;
                $display("FAIL %s cycle %0d: rear=%h front=%h expected rear=%h front=%h",
                         it.tag, it.cyc, rear_o, front_o, it.rear, it.front);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors += 1;
            checks += 1;
            $display("FAIL watchdog R1..: run did not finish, actual hung expected done");
            report();
            $finish;
        end
    end

    initial begin
        int k;
        rst_n = 1'b0; evt_code = '0; evt_valid = 1'b0; dbus = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        for (int f = 0; f < 8; f++) begin fsrc[f] = 0; fidx[f] = 0; end
        repeat (3) @(negedge clk);
        expect_rear(cyc + 1, 12'h000, "R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;
        expect_rear(cyc + 1, 12'h000, "R1 after release");
        send_evt(8'h21);
        @(negedge clk);

        // R2 R3 R4 R8 R10: code 0x21 fires ch0 (D3 W2) and ch5 (D0 W1).
        set_chan(0, 3, 2);
        set_chan(5, 0, 1);
        wr(8'h21, 12'h021);
        k = cyc + 1;
        expect_rear(k,     12'h020, "R3 zero delay ch5");
        expect_rear(k + 1, 12'h000, "R4 width one ch5");
        expect_rear(k + 2, 12'h000, "R3 ch0 waiting");
        expect_rear(k + 3, 12'h001, "R3 ch0 delay three");
        expect_rear(k + 4, 12'h001, "R4 ch0 width two");
        expect_rear(k + 5, 12'h000, "R4 ch0 end");
        send_evt(8'h21);
        repeat (6) @(negedge clk);

        // R2: invalid strobe and unmapped code fire nothing.
        k = cyc + 1;
        for (int j = 0; j < 7; j++) expect_rear(k + j, 12'h000, "R2 ignored event");
        evt_code = 8'h21; evt_valid = 1'b0;
        @(negedge clk);
        send_evt(8'h22);
        repeat (6) @(negedge clk);

        // R5: width 0 disables, then enabling width 2 makes it pulse.
        wr(8'h30, 12'h002);
        k = cyc + 1;
        for (int j = 0; j < 4; j++) expect_rear(k + j, 12'h000, "R5 width zero");
        send_evt(8'h30);
        repeat (4) @(negedge clk);
        set_chan(1, 0, 2);
        k = cyc + 1;
        expect_rear(k,     12'h002, "R5 enabled width");
        expect_rear(k + 1, 12'h002, "R5 enabled width");
        expect_rear(k + 2, 12'h000, "R5 enabled end");
        send_evt(8'h30);
        repeat (3) @(negedge clk);

        // R6: second fire two cycles later restarts the delay of four.
        set_chan(2, 4, 1);
        wr(8'h40, 12'h004);
        k = cyc + 1;
        for (int j = 0; j < 8; j++)
            expect_rear(k + j, (j == 6) ? 12'h004 : 12'h000, "R6 restart");
        send_evt(8'h40);
        @(negedge clk);
        send_evt(8'h40);
        repeat (6) @(negedge clk);

        // R11: mapping write and event with the same code on one edge.
        set_chan(4, 0, 1);
        k = cyc + 1;
        for (int j = 0; j < 3; j++) expect_rear(k + j, 12'h000, "R11 old entry used");
        wr_en = 1'b1; wr_addr = 10'h060; wr_data = 32'h010;
        evt_code = 8'h60; evt_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; evt_valid = 1'b0;
        repeat (3) @(negedge clk);
        k = cyc + 1;
        expect_rear(k,     12'h010, "R11 new entry");
        expect_rear(k + 1, 12'h000, "R11 new entry end");
        send_evt(8'h60);
        repeat (2) @(negedge clk);

        // R9: front selectors, bus bits and triggers, out-of-range index.
        set_front(0, 1'b1, 6);
        set_front(1, 1'b0, 5);
        set_front(2, 1'b0, 13);
        set_front(3, 1'b1, 0);
        dbus = 8'h41;
        expect_rear(cyc + 1, 12'h000, "R9 bus routing");
        @(negedge clk);
        k = cyc + 1;
        expect_rear(k,     12'h020, "R9 trigger routing ch5");
        expect_rear(k + 1, 12'h000, "R9 trigger routing");
        expect_rear(k + 3, 12'h001, "R9 default selector ch0");
        expect_rear(k + 4, 12'h001, "R8 rear ch0");
        expect_rear(k + 5, 12'h000, "R9 trigger routing end");
        send_evt(8'h21);
        repeat (6) @(negedge clk);

        // R7: inverted channel idles high and dips for its pulse.
        wr(256 + 3 * 4 + 2, 1);
        set_chan(3, 1, 2);
        wr(8'h50, 12'h008);
        k = cyc + 1;
        expect_rear(k,     12'h008, "R7 idle high");
        expect_rear(k + 1, 12'h000, "R7 active low");
        expect_rear(k + 2, 12'h000, "R7 active low");
        expect_rear(k + 3, 12'h008, "R7 back to idle");
        send_evt(8'h50);
        repeat (5) @(negedge clk);

        done = 1;
        if (sb_q.size() != 0) begin
            errors += 1;
            checks += 1;
            $display("FAIL R1..R11 scoreboard: %0d items left, expected 0", sb_q.size());
        end
        report();
        $finish;
    end

endmodule